// File: doc/BRIEF.md
# Base and Bound Address Relocator

This block sits between an address generator and the memory port. Each request carries an effective address. The block checks that address against a segment length held in a bound register. If the address is inside the segment, the block adds a base register to it and passes the physical address downstream as a stream beat. If the address lies outside the segment, the block drops the request and raises a one-cycle bounds fault instead.

The base and bound registers are loaded through a small register-write port. A privilege bit controls that port. The bit is held inside the block and is set by the mode-switching logic outside it. In supervisor mode a register write takes effect. In user mode the write is refused, both registers keep their values, and a one-cycle privilege fault is raised. Translation runs the same way in both modes.

Requests enter on a valid/ready channel and leave through one output register stage on a second valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or is being drained in that same cycle. While `mem_valid` is high and `mem_ready` is low, the output beat is held unchanged.

Top module: `bb_reloc`

## Requirements
- R1: An in-range request accepted in cycle n gives `mem_valid` high in cycle n+1. The address `mem_paddr` then equals the effective address, zero-extended, plus the base register, taken modulo 2^PADDR_W.
- R2: An accepted request whose effective address is greater than or equal to the bound register produces no output beat. It raises `bound_fault` for exactly one cycle, in cycle n+1.
- R3: The valid range is 0 to bound-1. An address equal to bound-1 is translated, an address equal to bound faults, and a bound of 0 makes every request fault.
- R4: A mode value of 0 means user mode and 1 means supervisor mode. When `mode_we` is high, `mode_wdata` becomes the mode in the next cycle. A register write in that same cycle is judged by the mode in force before the load.
- R5: In supervisor mode, `reg_we` with `reg_sel` = 0 loads `reg_wdata` into the base register, and `reg_sel` = 1 loads its low ADDR_W bits into the bound register. Requests accepted from the next cycle on use the new value. A request accepted in the same cycle as the write uses the old value.
- R6: In user mode, `reg_we` leaves both registers unchanged and raises `priv_fault` for exactly one cycle, in the next cycle. Later translations show that the old base and bound still apply.
- R7: Translation, the bounds check and bounds faults behave the same in user mode as in supervisor mode.
- R8: `req_ready` is equal to (not `mem_valid`) or `mem_ready`. While `mem_valid` is high and `mem_ready` is low, `mem_valid` and `mem_paddr` stay unchanged.
- R9: After reset, base and bound are 0, the mode is supervisor, and `mem_valid`, `bound_fault` and `priv_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load the privilege bit |
| mode_wdata | input | 1 | New privilege bit (0 user, 1 supervisor) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 bound |
| reg_wdata | input | PADDR_W | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Effective address |
| mem_valid | output | 1 | Physical address beat valid |
| mem_ready | input | 1 | Downstream can take the beat |
| mem_paddr | output | PADDR_W | Physical address |
| bound_fault | output | 1 | One-cycle pulse: accepted request was out of bounds |
| priv_fault | output | 1 | One-cycle pulse: register write refused in user mode |
| mode | output | 1 | Current privilege bit |

## Verification
Timing is counted from the input clock edge. `req_ready` is combinational and valid in the same cycle. `mem_valid`, `mem_paddr`, `bound_fault`, `priv_fault`, `mode` and new register values all take effect one edge after their stimulus. The bench drives inputs on the falling edge and checks `req_ready` just after that. It compares the registered outputs against a behavioural model at the next falling edge, which is exactly one rising edge after the stimulus. The stimulus mixes directed cases with random traffic and random back-pressure, so that writes, mode loads and requests fall into the same cycle.

// File: rtl/bb_reloc_pkg.sv
package bb_reloc_pkg;
  typedef enum logic {
    MODE_USER  = 1'b0,
    MODE_SUPER = 1'b1
  } priv_mode_e;

  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_BOUND = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/bb_reloc_regs.sv
module bb_reloc_regs
  import bb_reloc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_we,
  input  logic               mode_wdata,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [PADDR_W-1:0] reg_wdata,
  output logic [PADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0]  bound_q,
  output logic               mode_q,
  output logic               priv_fault_q
);
  logic wr_ok;
  assign wr_ok = reg_we && (mode_q == MODE_SUPER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q       <= '0;
      bound_q      <= '0;
      mode_q       <= MODE_SUPER;
      priv_fault_q <= 1'b0;
    end else begin
      if (wr_ok && reg_sel == SEL_BASE)  base_q  <= reg_wdata;
      if (wr_ok && reg_sel == SEL_BOUND) bound_q <= reg_wdata[ADDR_W-1:0];
      if (mode_we) mode_q <= mode_wdata;
      priv_fault_q <= reg_we && (mode_q == MODE_USER);
    end
  end

  // R6: a write attempted in user mode leaves the registers alone and faults
  p_user_write_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && mode_q == MODE_USER) |=> (priv_fault_q && $stable(base_q) && $stable(bound_q)));

  // R5: a supervisor write to the base register lands one cycle later
  p_super_base_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && mode_q == MODE_SUPER && reg_sel == SEL_BASE) |=> (base_q == $past(reg_wdata)));

  // R4: a mode load is visible in the next cycle
  p_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(mode_wdata)));
endmodule

// File: rtl/bb_reloc_xlate.sv
module bb_reloc_xlate #(
  parameter int ADDR_W  = 16,
  parameter int PADDR_W = 20
) (
  input  logic [ADDR_W-1:0]  eff_addr,
  input  logic [PADDR_W-1:0] base,
  input  logic [ADDR_W-1:0]  bound,
  output logic [PADDR_W-1:0] phys_addr,
  output logic               in_range
);
  localparam int PAD_W = PADDR_W - ADDR_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign phys_addr = base + {{PAD_W{1'b0}}, eff_addr};
    end else begin : g_nopad
      assign phys_addr = base + eff_addr[PADDR_W-1:0];
    end
  endgenerate

  assign in_range = (eff_addr < bound);

  initial begin
    assert (PADDR_W >= ADDR_W) else $error("PADDR_W must not be narrower than ADDR_W");
  end
endmodule

// File: rtl/bb_reloc_outbuf.sv
module bb_reloc_outbuf #(
  parameter int PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               in_range,
  input  logic [PADDR_W-1:0] phys_addr,
  input  logic               mem_ready,
  output logic               mem_valid,
  output logic [PADDR_W-1:0] mem_paddr,
  output logic               bound_fault
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid   <= 1'b0;
      mem_paddr   <= '0;
      bound_fault <= 1'b0;
    end else begin
      bound_fault <= accept && !in_range;
      if (accept && in_range) begin
        mem_valid <= 1'b1;
        mem_paddr <= phys_addr;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
    end
  end

  // R8: a stalled beat is held unchanged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_paddr)));

  // R2: an out-of-range acceptance faults and creates no new beat
  p_fault_no_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (bound_fault && (mem_valid == $past(mem_valid && !mem_ready))));
endmodule

// File: rtl/bb_reloc.sv
module bb_reloc
  import bb_reloc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_we,
  input  logic               mode_wdata,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [PADDR_W-1:0] reg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [PADDR_W-1:0] mem_paddr,
  output logic               bound_fault,
  output logic               priv_fault,
  output logic               mode
);
  logic [PADDR_W-1:0] base_q;
  logic [ADDR_W-1:0]  bound_q;
  logic [PADDR_W-1:0] phys_addr;
  logic               in_range;
  logic               accept;

  assign req_ready = !mem_valid || mem_ready;
  assign accept    = req_valid && req_ready;

  bb_reloc_regs #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .base_q(base_q), .bound_q(bound_q), .mode_q(mode), .priv_fault_q(priv_fault)
  );

  bb_reloc_xlate #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W)) xlate_i (
    .eff_addr(req_addr), .base(base_q), .bound(bound_q),
    .phys_addr(phys_addr), .in_range(in_range)
  );

  bb_reloc_outbuf #(.PADDR_W(PADDR_W)) outbuf_i (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .in_range(in_range), .phys_addr(phys_addr),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_paddr(mem_paddr), .bound_fault(bound_fault)
  );

  // R1: an accepted in-range request becomes a beat carrying address plus base
  p_translate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_addr < bound_q)) |=>
      (mem_valid && mem_paddr == PADDR_W'($past(base_q) + PADDR_W'($past(req_addr)))));

  // R2: faults are single-cycle pulses tied to an acceptance
  p_fault_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bound_fault |-> $past(accept));
endmodule

// File: tb/bb_reloc_tb_top.sv
module bb_reloc_tb_top;
  localparam int AW = 16;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 0, mode_wdata = 0, reg_we = 0, reg_sel = 0;
  logic [PW-1:0] reg_wdata = '0;
  logic req_valid = 0, mem_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, mem_valid, bound_fault, priv_fault, mode;
  logic [PW-1:0] mem_paddr;

  always #4 clk = ~clk;

  bb_reloc #(.ADDR_W(AW), .PADDR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_paddr(mem_paddr),
    .bound_fault(bound_fault), .priv_fault(priv_fault), .mode(mode)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  logic [PW-1:0] m_base = '0;
  logic [AW-1:0] m_bound = '0;
  logic m_mode = 1'b1;
  logic m_ov = 0, m_bf = 0, m_pf = 0;
  logic [PW-1:0] m_pa = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: compare registered outputs, drive new inputs, advance model
  task automatic step(input logic mwe, input logic mwd, input logic rwe, input logic rsel,
                      input logic [PW-1:0] rwd, input logic rv, input logic [AW-1:0] ra,
                      input logic mr);
    logic acc;
    @(negedge clk);
    chk("R1/R8 mem_valid", 32'(mem_valid), 32'(m_ov));
    if (m_ov) chk("R1 mem_paddr", 32'(mem_paddr), 32'(m_pa));
    chk("R2/R3 bound_fault", 32'(bound_fault), 32'(m_bf));
    chk("R6 priv_fault", 32'(priv_fault), 32'(m_pf));
    chk("R4 mode", 32'(mode), 32'(m_mode));
    mode_we = mwe; mode_wdata = mwd; reg_we = rwe; reg_sel = rsel; reg_wdata = rwd;
    req_valid = rv; req_addr = ra; mem_ready = mr;
    #1;
    chk("R8 req_ready", 32'(req_ready), 32'(!m_ov || mr));
    acc = rv && (!m_ov || mr);
    m_bf = acc && (ra >= m_bound);
    if (acc && ra < m_bound) begin
      m_ov = 1;
      m_pa = m_base + PW'(ra);
    end else if (mr) m_ov = 0;
    m_pf = rwe && !m_mode;
    if (rwe && m_mode) begin
      if (!rsel) m_base = rwd; else m_bound = rwd[AW-1:0];
    end
    if (mwe) m_mode = mwd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0, '0, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 mem_valid", 32'(mem_valid), 0);
    chk("R9 bound_fault", 32'(bound_fault), 0);
    chk("R9 priv_fault", 32'(priv_fault), 0);
    chk("R9 mode", 32'(mode), 1);
    rst_n = 1'b1;
    // R9/R3: bound 0 after reset, so everything faults
    step(0, 0, 0, 0, '0, 1, 16'h0000, 1);
    idle(1);
    // R5: supervisor writes base and bound
    step(0, 0, 1, 0, 20'h01000, 0, '0, 1);
    step(0, 0, 1, 1, 20'h00100, 0, '0, 1);
    // R1/R3: in range, last valid address, equal to bound, beyond
    step(0, 0, 0, 0, '0, 1, 16'h0000, 1);
    step(0, 0, 0, 0, '0, 1, 16'h00FF, 1);
    step(0, 0, 0, 0, '0, 1, 16'h0100, 1);
    step(0, 0, 0, 0, '0, 1, 16'h0200, 1);
    idle(1);
    // R8: back-pressure holds the beat
    step(0, 0, 0, 0, '0, 1, 16'h0010, 0);
    step(0, 0, 0, 0, '0, 1, 16'h0020, 0);
    step(0, 0, 0, 0, '0, 1, 16'h0020, 0);
    step(0, 0, 0, 0, '0, 1, 16'h0020, 1);
    idle(2);
    // R5: write and request in the same cycle, old base applies to that request
    step(0, 0, 1, 0, 20'hFFF80, 1, 16'h0004, 1);
    step(0, 0, 0, 0, '0, 1, 16'h00F0, 1);  // wraps modulo 2^PW (R1)
    // R4: mode load with a same-cycle write judged by the old (supervisor) mode
    step(1, 0, 1, 1, 20'h00040, 0, '0, 1);
    // R6/R7: user mode refuses writes, translation still works
    step(0, 0, 1, 0, 20'h22222, 1, 16'h003F, 1);
    step(0, 0, 1, 1, 20'h0FFFF, 1, 16'h0040, 1);
    step(0, 0, 0, 0, '0, 1, 16'h0030, 1);
    // R4: back to supervisor; a write in that cycle still refused (old mode user)
    step(1, 1, 1, 1, 20'h00000, 0, '0, 1);
    step(0, 0, 0, 0, '0, 1, 16'h0001, 1);
    step(0, 0, 1, 1, 20'h00000, 0, '0, 1);
    step(0, 0, 0, 0, '0, 1, 16'h0000, 1);   // R3: bound 0 faults
    step(0, 0, 1, 1, 20'h08000, 0, '0, 1);
    // random traffic in both modes with random back-pressure (R1, R2, R5, R6, R7, R8)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] && r[1] && r[2] && r[3], r[4],
           r[5] && r[6] && r[7], r[8], PW'($urandom),
           r[9] || r[10], AW'($urandom), r[11] || r[12]);
    end
    idle(3);
    summary();
  end
endmodule